// File: doc/BRIEF.md
# I2C Control-Register Write Slave

This block is a write-only I2C target that fills a small bank of 8-bit configuration registers. The bus lines SCL and SDA arrive from the pads asynchronously. Each one passes through a synchronizer clocked by a much faster system clock, and all bus events are detected in that clock domain. A transfer starts with a START condition. The master then sends the 7-bit device address and a direction bit. For a write, it sends one byte that selects a register, followed by any number of data bytes. Each data byte lands in the register the internal pointer selects, and the pointer then steps to the next register. After the last register the pointer returns to the first one.

The block acknowledges each byte it accepts by enabling an open-drain pull-down on SDA for the ninth clock. The pad itself is outside the block. If the address does not match, the block stays silent until the next START or STOP. A read request with a matching address is acknowledged, but the block returns no data: it leaves SDA released and waits for the bus to end the transfer. The register contents are driven out in parallel, so other logic can read them at any time.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, every register reads 00H and the SDA pull-down enable is low.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP at any point returns the block to idle with SDA released, and a partly received byte is discarded.
- R3: A first byte whose top seven bits are 0110001 and whose last bit is 0 is acknowledged, and the block then expects a register-select byte.
- R4: A first byte with any other 7-bit address is not acknowledged. Until the next START or STOP the block never pulls SDA and changes no register.
- R5: The pull-down enable turns on only while SCL is low, after the falling edge of the 8th clock of a byte. It turns off after the falling edge of the 9th clock.
- R6: Bits 1:0 of the register-select byte choose register 0, 1 or 2, and bits 7:2 are ignored. The byte is acknowledged, and the next byte, sent MSB first, is written to the chosen register and acknowledged.
- R7: After each data byte the pointer advances by one, and from register 2 it returns to register 0. Further bytes in the same transfer therefore overwrite earlier registers.
- R8: A register-select value of 3 chooses no register. The next data byte is acknowledged and discarded, and the pointer then moves to register 0.
- R9: A first byte with address 0110001 and last bit 1 is acknowledged. After that the block keeps SDA released on every clock and changes no register until the next START or STOP.
- R10: A repeated START in the middle of a byte discards that byte, writes nothing, and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line from the pad, asynchronous |
| sda_in | input | 1 | Bus data line from the pad, asynchronous |
| sda_pull | output | 1 | Enable for the open-drain pull-down on SDA (1 = drive low) |
| cfg_q | output | 24 | Register contents, register n in bits 8n+7:8n |

## Verification
The write path is exercised with single-byte writes to each register and with a four-byte burst that wraps the pointer. Register-select values with the upper bits set show that only the two low bits count, and the value 3 shows that its data byte is dropped. A wrong address, a read request, a repeated START halfway through a data byte, and a STOP halfway through the register-select byte each test a different exit from the byte engine. Checking the acknowledge or its absence, and whether the registers stay unchanged, tells these exits apart. A behavioural model of the bus fed with the same sampled line values predicts the pull-down enable and every register on every clock, which fixes the acknowledge window to the exact cycle.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB,
      ST_DATA,
      ST_RDACK,
      ST_IGNORE
   } link_state_t;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
   import i2c_cfg_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_in,
   input  logic     sda_in,
   output bus_evt_t evt,
   output logic     scl_lvl
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   localparam int LINES = 2;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] synced;
   logic [LINES-1:0] delayed;

   assign raw = {scl_in, sda_in};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain      <= '1;
            delayed[l] <= 1'b1;
         end else begin
            chain      <= {chain[STAGES-2:0], raw[l]};
            delayed[l] <= chain[STAGES-1];
         end
      end
      assign synced[l] = chain[STAGES-1];
   end

   logic scl_now, scl_was, sda_now, sda_was;
   assign scl_now = synced[1];
   assign scl_was = delayed[1];
   assign sda_now = synced[0];
   assign sda_was = delayed[0];

   always_comb begin
      evt.start = scl_now & scl_was & sda_was & ~sda_now;
      evt.stop  = scl_now & scl_was & ~sda_was & sda_now;
      evt.rise  = scl_now & ~scl_was;
      evt.fall  = ~scl_now & scl_was;
      evt.sda   = sda_now;
   end

   assign scl_lvl = scl_now;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
   import i2c_cfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b0110001,
   parameter int         PTR_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_evt_t         evt,
   output logic             sda_pull,
   output logic             wr_req,
   output logic [7:0]       wr_data,
   output logic             ld_ptr,
   output logic [PTR_W-1:0] ld_val,
   output link_state_t      state_o
);

   localparam int         BYTE_W   = 8;
   localparam logic [3:0] BIT_LAST = 4'(BYTE_W);

   link_state_t       state;
   logic [3:0]        nbits;
   logic [BYTE_W-1:0] shreg;
   logic              in_ack;

   logic active;
   assign active = (state != ST_IDLE) && (state != ST_IGNORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         nbits    <= '0;
         shreg    <= '0;
         in_ack   <= 1'b0;
         sda_pull <= 1'b0;
         wr_req   <= 1'b0;
         ld_ptr   <= 1'b0;
      end else begin
         wr_req <= 1'b0;
         ld_ptr <= 1'b0;
         if (evt.start) begin
            state    <= ST_ADDR;
            nbits    <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
         end else if (evt.stop) begin
            state    <= ST_IDLE;
            nbits    <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
         end else if (active) begin
            if (evt.rise && !in_ack && nbits != BIT_LAST) begin
               shreg <= {shreg[BYTE_W-2:0], evt.sda};
               nbits <= nbits + 4'd1;
            end else if (evt.fall && in_ack) begin
               in_ack   <= 1'b0;
               sda_pull <= 1'b0;
               nbits    <= '0;
               if (state == ST_RDACK) state <= ST_IGNORE;
            end else if (evt.fall && nbits == BIT_LAST) begin
               unique case (state)
                  ST_ADDR: begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        in_ack   <= 1'b1;
                        sda_pull <= 1'b1;
                        state    <= shreg[0] ? ST_RDACK : ST_SUB;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
                  ST_SUB: begin
                     in_ack   <= 1'b1;
                     sda_pull <= 1'b1;
                     ld_ptr   <= 1'b1;
                     state    <= ST_DATA;
                  end
                  ST_DATA: begin
                     in_ack   <= 1'b1;
                     sda_pull <= 1'b1;
                     wr_req   <= 1'b1;
                  end
                  default: state <= ST_IGNORE;
               endcase
            end
         end
      end
   end

   assign wr_data = shreg;
   assign ld_val  = shreg[PTR_W-1:0];
   assign state_o = state;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
   parameter int NUM_REGS = 3,
   parameter int REG_W    = 8,
   parameter int PTR_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_ptr,
   input  logic [PTR_W-1:0]          ld_val,
   input  logic                      wr_req,
   input  logic [REG_W-1:0]          wr_data,
   output logic [NUM_REGS*REG_W-1:0] regs_q,
   output logic [PTR_W-1:0]          ptr_q
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   generate
      if (NUM_REGS > (1 << PTR_W)) begin : g_bad_ptr
         $error("cfg_reg_bank: PTR_W too narrow for NUM_REGS");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ld_ptr) begin
         ptr_q <= ld_val;
      end else if (wr_req) begin
         ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic hit;
      assign hit = wr_req && (ptr_q == PTR_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[r*REG_W +: REG_W] <= '0;
         end else if (hit) begin
            regs_q[r*REG_W +: REG_W] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
   import i2c_cfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b0110001,
   parameter int         NUM_REGS    = 3,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_pull,
   output logic [NUM_REGS*8-1:0] cfg_q
);

   localparam int REG_W = 8;
   localparam int PTR_W = (NUM_REGS <= 2) ? 1 : $clog2(NUM_REGS);

   generate
      if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_regs
         $error("i2c_cfg_slave: NUM_REGS must lie in 2..256");
      end
   endgenerate

   bus_evt_t         evt;
   logic             scl_lvl;
   logic             stop_seen;
   logic             wr_req;
   logic [REG_W-1:0] wr_data;
   logic             ld_ptr;
   logic [PTR_W-1:0] ld_val;
   logic [PTR_W-1:0] ptr_q;
   link_state_t      link_state;

   assign stop_seen = evt.stop;

   i2c_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_in  (scl_in),
      .sda_in  (sda_in),
      .evt     (evt),
      .scl_lvl (scl_lvl)
   );

   i2c_link_fsm #(
      .DEV_ADDR (DEV_ADDR),
      .PTR_W    (PTR_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .sda_pull (sda_pull),
      .wr_req   (wr_req),
      .wr_data  (wr_data),
      .ld_ptr   (ld_ptr),
      .ld_val   (ld_val),
      .state_o  (link_state)
   );

   cfg_reg_bank #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .PTR_W    (PTR_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_ptr  (ld_ptr),
      .ld_val  (ld_val),
      .wr_req  (wr_req),
      .wr_data (wr_data),
      .regs_q  (cfg_q),
      .ptr_q   (ptr_q)
   );

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
   import i2c_cfg_pkg::*;
#(
   parameter int NUM_REGS = 3,
   parameter int PTR_W    = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sda_pull,
   input logic                  scl_lvl,
   input logic                  stop_seen,
   input logic                  wr_req,
   input logic [PTR_W-1:0]      ptr_q,
   input link_state_t           link_state,
   input logic [NUM_REGS*8-1:0] cfg_q
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   // R5: pull-down is switched on only while SCL is low
   assert_pull_on_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_lvl);

   // R2: a STOP leaves SDA released
   assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !sda_pull);

   // R6: registers move only after a write strobe from the byte engine
   assert_regs_need_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |-> $past(wr_req));

   // R7: pointer returns to register 0 after the last one
   assert_ptr_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && ptr_q >= LAST) |=> (ptr_q == '0));

   // R4: while ignoring the bus nothing is driven or written
   assert_ignore_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == ST_IGNORE) |-> (!sda_pull && !wr_req));

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(
   .NUM_REGS (NUM_REGS),
   .PTR_W    (PTR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sda_pull   (sda_pull),
   .scl_lvl    (scl_lvl),
   .stop_seen  (stop_seen),
   .wr_req     (wr_req),
   .ptr_q      (ptr_q),
   .link_state (link_state),
   .cfg_q      (cfg_q)
);

// File: tb/sim_i2c_cfg_slave.sv
`timescale 1ns/1ps
module sim_i2c_cfg_slave;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_pull;
   logic [23:0] cfg_q;
   wire         sda_line = m_sda & ~sda_pull;

   int n_cmp = 0;
   int n_bad = 0;
   bit cmp_en = 1'b0;

   always #4 clk = ~clk;

   i2c_cfg_slave u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (m_scl),
      .sda_in   (sda_line),
      .sda_pull (sda_pull),
      .cfg_q    (cfg_q)
   );

   // ---------------- behavioural reference model ----------------
   int  h_scl[4];
   int  h_sda[4];
   int  m_mode;         // 0 idle,1 addr,2 select,3 data,4 read-ack,5 ignore
   int  m_cnt;
   int  m_byte;
   bit  m_ack;
   bit  m_pull;
   int  m_ptr;
   int  m_regs[3];
   bit  m_pend;
   int  m_pdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin h_scl[i] = 1; h_sda[i] = 1; end
         m_mode = 0; m_cnt = 0; m_byte = 0; m_ack = 0; m_pull = 0;
         m_ptr = 0; m_pend = 0; m_pdata = 0;
         for (int i = 0; i < 3; i++) m_regs[i] = 0;
      end else begin
         if (m_pend) begin
            if (m_ptr < 3) m_regs[m_ptr] = m_pdata;
            m_ptr = (m_ptr >= 2) ? 0 : m_ptr + 1;
            m_pend = 0;
         end
         for (int i = 3; i > 0; i--) begin h_scl[i] = h_scl[i-1]; h_sda[i] = h_sda[i-1]; end
         h_scl[0] = int'(m_scl);
         h_sda[0] = int'(sda_line);
         if (h_scl[2] == 1 && h_scl[3] == 1 && h_sda[3] == 1 && h_sda[2] == 0) begin
            m_mode = 1; m_cnt = 0; m_ack = 0; m_pull = 0;
         end else if (h_scl[2] == 1 && h_scl[3] == 1 && h_sda[3] == 0 && h_sda[2] == 1) begin
            m_mode = 0; m_cnt = 0; m_ack = 0; m_pull = 0;
         end else if (m_mode != 0 && m_mode != 5) begin
            if (h_scl[2] == 1 && h_scl[3] == 0 && !m_ack && m_cnt < 8) begin
               m_byte = ((m_byte << 1) | h_sda[2]) & 8'hFF;
               m_cnt++;
            end else if (h_scl[2] == 0 && h_scl[3] == 1 && m_ack) begin
               m_ack = 0; m_pull = 0; m_cnt = 0;
               if (m_mode == 4) m_mode = 5;
            end else if (h_scl[2] == 0 && h_scl[3] == 1 && m_cnt == 8) begin
               case (m_mode)
                  1: if ((m_byte >> 1) == 'h31) begin
                        m_ack = 1; m_pull = 1; m_mode = (m_byte & 1) ? 4 : 2;
                     end else m_mode = 5;
                  2: begin m_ack = 1; m_pull = 1; m_ptr = m_byte % 4; m_mode = 3; end
                  3: begin m_ack = 1; m_pull = 1; m_pend = 1; m_pdata = m_byte; end
                  default: m_mode = 5;
               endcase
            end
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         n_cmp++;
         if (sda_pull !== m_pull) begin
            n_bad++;
            $display("FAIL R5 per-clock pull: actual=%0b expected=%0b t=%0t", sda_pull, m_pull, $time);
         end
         for (int i = 0; i < 3; i++) begin
            n_cmp++;
            if (cfg_q[8*i +: 8] !== m_regs[i][7:0]) begin
               n_bad++;
               $display("FAIL R6 per-clock reg%0d: actual=%02h expected=%02h t=%0t",
                        i, cfg_q[8*i +: 8], m_regs[i][7:0], $time);
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic wc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      if (m_scl == 1'b0) begin
         m_sda = 1'b1; wc(4);
         m_scl = 1'b1; wc(8);
      end
      m_sda = 1'b0; wc(8);
      m_scl = 1'b0; wc(4);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wc(4);
      m_scl = 1'b1; wc(8);
      m_sda = 1'b1; wc(8);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; wc(4);
      m_scl = 1'b1; wc(8);
      m_scl = 1'b0; wc(4);
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
   endtask

   task automatic ack_clock(output logic acked);
      m_sda = 1'b1; wc(4);
      m_scl = 1'b1; wc(4);
      acked = ~sda_line;
      wc(4);
      m_scl = 1'b0; wc(4);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      send_bits(v, 8);
      ack_clock(acked);
   endtask

   task automatic read_byte(output logic [7:0] v);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wc(4);
         m_scl = 1'b1; wc(4);
         v[i] = sda_line;
         wc(4);
         m_scl = 1'b0;
      end
      wc(4);
   endtask

   task automatic check_regs(input string tag, input logic [7:0] r0,
                             input logic [7:0] r1, input logic [7:0] r2);
      check({tag, " reg0"}, {24'h0, cfg_q[7:0]},   {24'h0, r0});
      check({tag, " reg1"}, {24'h0, cfg_q[15:8]},  {24'h0, r1});
      check({tag, " reg2"}, {24'h0, cfg_q[23:16]}, {24'h0, r2});
   endtask

   // ---------------- scenarios ----------------
   task automatic run_all();
      logic a;
      logic [7:0] rd;

      wc(5);
      rst_n = 1'b1;
      wc(2);
      check("R1 reset pull", {31'h0, sda_pull}, 32'h0);
      check_regs("R1 reset", 8'h00, 8'h00, 8'h00);
      cmp_en = 1'b1;

      // single write to register 0
      bus_start();
      send_byte(8'h62, a); check("R3 address ack", {31'h0, a}, 32'h1);
      wc(4); check("R5 pull released after ack", {31'h0, sda_pull}, 32'h0);
      send_byte(8'h00, a); check("R6 select ack", {31'h0, a}, 32'h1);
      send_byte(8'hA5, a); check("R6 data ack", {31'h0, a}, 32'h1);
      bus_stop();
      check_regs("R6 single write", 8'hA5, 8'h00, 8'h00);

      // burst from register 1 wrapping to register 0
      bus_start();
      send_byte(8'h62, a);
      send_byte(8'h01, a);
      send_byte(8'h3C, a);
      send_byte(8'h7E, a);
      send_byte(8'h81, a); check("R7 wrapped byte ack", {31'h0, a}, 32'h1);
      bus_stop();
      check_regs("R7 burst wrap", 8'h81, 8'h3C, 8'h7E);

      // upper select bits ignored: FE selects register 2
      bus_start();
      send_byte(8'h62, a);
      send_byte(8'hFE, a); check("R6 select FE ack", {31'h0, a}, 32'h1);
      send_byte(8'h55, a);
      bus_stop();
      check_regs("R6 upper bits ignored", 8'h81, 8'h3C, 8'h55);

      // select 3: first byte dropped, next goes to register 0
      bus_start();
      send_byte(8'h62, a);
      send_byte(8'h03, a);
      send_byte(8'h99, a); check("R8 dropped byte ack", {31'h0, a}, 32'h1);
      check_regs("R8 after dropped byte", 8'h81, 8'h3C, 8'h55);
      send_byte(8'h11, a);
      bus_stop();
      check_regs("R8 pointer to reg0", 8'h11, 8'h3C, 8'h55);

      // wrong address 0110010
      bus_start();
      send_byte(8'h64, a); check("R4 no ack on mismatch", {31'h0, a}, 32'h0);
      send_byte(8'h00, a); check("R4 silent after mismatch", {31'h0, a}, 32'h0);
      send_byte(8'hAA, a);
      bus_stop();
      check_regs("R4 mismatch no write", 8'h11, 8'h3C, 8'h55);

      // read request
      bus_start();
      send_byte(8'h63, a); check("R9 read address ack", {31'h0, a}, 32'h1);
      read_byte(rd); check("R9 line released in read", {24'h0, rd}, 32'hFF);
      send_bit(1'b1);
      bus_stop();
      check_regs("R9 read no write", 8'h11, 8'h3C, 8'h55);

      // repeated START in the middle of a data byte
      bus_start();
      send_byte(8'h62, a);
      send_byte(8'h01, a);
      send_bits(8'hF0, 4);
      bus_start();
      send_byte(8'h62, a); check("R10 ack after restart", {31'h0, a}, 32'h1);
      check_regs("R10 partial byte dropped", 8'h11, 8'h3C, 8'h55);
      send_byte(8'h01, a);
      send_byte(8'h42, a);
      bus_stop();
      check_regs("R10 write after restart", 8'h11, 8'h42, 8'h55);

      // STOP in the middle of the select byte
      bus_start();
      send_byte(8'h62, a);
      send_bits(8'h02, 3);
      bus_stop();
      wc(4);
      check("R2 stop releases", {31'h0, sda_pull}, 32'h0);
      bus_start();
      send_byte(8'h62, a); check("R2 start after stop", {31'h0, a}, 32'h1);
      bus_stop();
      check_regs("R2 stop mid byte", 8'h11, 8'h42, 8'h55);
      wc(10);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule